// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block decides, once per timekeeping update, whether the running time has reached the programmed alarm. It takes the seconds, minutes and hours bytes of the running clock and the three alarm bytes. Each byte is turned into a plain binary field value under the current number format (binary or BCD) and hour convention (12-hour or 24-hour). The fields are then compared one by one.

An alarm byte whose two top bits are both set is a "don't care" for its field. With all three bytes set that way, every update gives a match. The result is a single-cycle pulse for the interrupt status logic, which sets its alarm flag from it whether or not the alarm interrupt is enabled. No comparison is made while the clock is held for setting or while its prescaler is held in reset, because no update takes place in either state.

Top module: `alm_cmp_top`

## Requirements
- R1: After reset is released, `match_o` is 0.
- R2: In binary 24-hour mode (`bin_mode_i`=1, `hr24_i`=1), when `upd_i` is 1 for one cycle and all three alarm bytes equal the time bytes, `match_o` is 1 in the following cycle only.
- R3: With `bin_mode_i`=0, every byte is read as BCD (upper nibble tens, lower nibble units). The alarm matches by decoded value, so alarm 0x59 matches time 0x59 and not time 0x3B.
- R4: An alarm byte with bits 7 and 6 both 1 (for example 0xC0 or 0xFF) matches any time value in its field.
- R5: When all three alarm bytes are wildcards, every qualified update produces a match pulse.
- R6: With `hr24_i`=0, bit 7 of an hour byte is the PM flag, and the hour is taken as (value mod 12) plus 12 when PM. So 12 AM (0x12 in BCD) equals hour 0 and 12 PM (0x92) equals hour 12. An AM and a PM hour with the same digits do not match.
- R7: Without `upd_i`, `match_o` stays 0 whatever the inputs are.
- R8: While `set_mode_i` or `div_hold_i` is 1, an update produces no match pulse.
- R9: A mismatch in any single non-wildcard field suppresses the pulse.
- R10: The alarm bytes present in the update cycle are the ones compared, so an alarm write lands on the next update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | One-cycle strobe: a new time is present on the time bytes |
| set_mode_i | input | 1 | Clock held for setting; updates are ignored |
| div_hold_i | input | 1 | Prescaler held in reset; updates are ignored |
| bin_mode_i | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_i | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM in bit 7 |
| now_sec_i | input | 8 | Current seconds byte |
| now_min_i | input | 8 | Current minutes byte |
| now_hour_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hour_i | input | 8 | Alarm hours byte |
| match_o | output | 1 | One-cycle alarm match pulse |

## Verification
The hardest cases are 12-hour equivalences, where two different byte values stand for the same hour (12 AM against 0, 12 PM against 12), and partial wildcards mixed with a mismatch in another field. Random stimulus hits neither often. The random alarm generator therefore copies each time field with high probability and otherwise draws a wildcard or a fresh value. This produces near-misses in one field at a time across all four format combinations. Directed steps then cover the 12 o'clock encodings, the gating inputs, and an alarm change made in the same cycle as the strobe.

// File: rtl/alm_cmp_pkg.sv
package alm_cmp_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned N_FIELDS = 3;
  localparam int unsigned HOUR_IDX = 2;

  typedef struct packed {
    logic bin;
    logic h24;
  } fmt_t;
endpackage

// File: rtl/alm_field_dec.sv
module alm_field_dec
  import alm_cmp_pkg::*;
#(
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [BYTE_W-1:0] raw_i,
  input  fmt_t              fmt_i,
  output logic [BYTE_W-1:0] val_o,
  output logic              wild_o
);
  localparam int unsigned NIB = BYTE_W / 2;

  logic [BYTE_W-1:0] body;
  logic [BYTE_W-1:0] bcd_val;
  logic [BYTE_W-1:0] plain;

  assign wild_o = &raw_i[BYTE_W-1 -: 2];

  always_comb begin
    body = raw_i;
    if (IS_HOUR && !fmt_i.h24) body[BYTE_W-1] = 1'b0;
  end

  assign bcd_val = BYTE_W'(body[BYTE_W-1 -: NIB]) * BYTE_W'(10) + BYTE_W'(body[NIB-1:0]);
  assign plain   = fmt_i.bin ? body : bcd_val;

  generate
    if (IS_HOUR) begin : g_hour
      logic [BYTE_W-1:0] base12;
      assign base12 = plain % BYTE_W'(12);
      assign val_o  = fmt_i.h24 ? plain
                    : (raw_i[BYTE_W-1] ? base12 + BYTE_W'(12) : base12);
    end else begin : g_plain
      assign val_o = plain;
    end
  endgenerate
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
  import alm_cmp_pkg::*;
(
  input  logic [BYTE_W-1:0] now_val_i,
  input  logic [BYTE_W-1:0] alm_val_i,
  input  logic              alm_wild_i,
  output logic              hit_o
);
  assign hit_o = alm_wild_i | (now_val_i == alm_val_i);
endmodule

// File: rtl/alm_pulse_gen.sv
module alm_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic set_mode_i,
  input  logic div_hold_i,
  input  logic all_hit_i,
  output logic match_o
);
  logic fire;

  // no update occurs while held, so nothing to compare
  assign fire = upd_i & ~set_mode_i & ~div_hold_i & all_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_o <= 1'b0;
    else         match_o <= fire;
  end
endmodule

// File: rtl/alm_cmp_top.sv
module alm_cmp_top
  import alm_cmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              set_mode_i,
  input  logic              div_hold_i,
  input  logic              bin_mode_i,
  input  logic              hr24_i,
  input  logic [BYTE_W-1:0] now_sec_i,
  input  logic [BYTE_W-1:0] now_min_i,
  input  logic [BYTE_W-1:0] now_hour_i,
  input  logic [BYTE_W-1:0] alm_sec_i,
  input  logic [BYTE_W-1:0] alm_min_i,
  input  logic [BYTE_W-1:0] alm_hour_i,
  output logic              match_o
);
  fmt_t              fmt;
  logic [BYTE_W-1:0] now_raw [N_FIELDS];
  logic [BYTE_W-1:0] alm_raw [N_FIELDS];
  logic [N_FIELDS-1:0] field_hit;

  assign fmt.bin = bin_mode_i;
  assign fmt.h24 = hr24_i;

  assign now_raw[0] = now_sec_i;
  assign now_raw[1] = now_min_i;
  assign now_raw[2] = now_hour_i;
  assign alm_raw[0] = alm_sec_i;
  assign alm_raw[1] = alm_min_i;
  assign alm_raw[2] = alm_hour_i;

  generate
    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      localparam bit HR = (f == HOUR_IDX);
      logic [BYTE_W-1:0] now_val, alm_val;
      logic              now_wild_unused, alm_wild;

      alm_field_dec #(.IS_HOUR(HR)) u_now_dec (
        .raw_i (now_raw[f]),
        .fmt_i (fmt),
        .val_o (now_val),
        .wild_o(now_wild_unused)
      );

      alm_field_dec #(.IS_HOUR(HR)) u_alm_dec (
        .raw_i (alm_raw[f]),
        .fmt_i (fmt),
        .val_o (alm_val),
        .wild_o(alm_wild)
      );

      alm_field_cmp u_cmp (
        .now_val_i (now_val),
        .alm_val_i (alm_val),
        .alm_wild_i(alm_wild),
        .hit_o     (field_hit[f])
      );
    end
  endgenerate

  alm_pulse_gen u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .set_mode_i(set_mode_i),
    .div_hold_i(div_hold_i),
    .all_hit_i (&field_hit),
    .match_o   (match_o)
  );
endmodule

// File: rtl/alm_cmp_chk.sv
module alm_cmp_chk
  import alm_cmp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              set_mode_i,
  input logic              div_hold_i,
  input logic              bin_mode_i,
  input logic              hr24_i,
  input logic [BYTE_W-1:0] now_sec_i,
  input logic [BYTE_W-1:0] alm_sec_i,
  input logic [BYTE_W-1:0] alm_min_i,
  input logic [BYTE_W-1:0] alm_hour_i,
  input logic              match_o
);
  assert_pulse_needs_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $past(upd_i));

  assert_no_match_when_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (!$past(set_mode_i) && !$past(div_hold_i)));

  assert_all_wild_fires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !set_mode_i && !div_hold_i && (&alm_sec_i[7:6]) && (&alm_min_i[7:6])
     && (&alm_hour_i[7:6])) |=> match_o);

  assert_sec_mismatch_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && bin_mode_i && hr24_i && !(&alm_sec_i[7:6]) && (alm_sec_i != now_sec_i))
    |=> !match_o);
endmodule

bind alm_cmp_top alm_cmp_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .upd_i     (upd_i),
  .set_mode_i(set_mode_i),
  .div_hold_i(div_hold_i),
  .bin_mode_i(bin_mode_i),
  .hr24_i    (hr24_i),
  .now_sec_i (now_sec_i),
  .alm_sec_i (alm_sec_i),
  .alm_min_i (alm_min_i),
  .alm_hour_i(alm_hour_i),
  .match_o   (match_o)
);

// File: tb/alm_cmp_top_tb_top.sv
module alm_cmp_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd = 0, set_m = 0, hold = 0, bin = 1, h24 = 1;
  logic [7:0] ns = 0, nm = 0, nh = 0, as_ = 0, am = 0, ah = 0;
  logic match;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  alm_cmp_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .upd_i(upd), .set_mode_i(set_m), .div_hold_i(hold),
    .bin_mode_i(bin), .hr24_i(h24), .now_sec_i(ns), .now_min_i(nm), .now_hour_i(nh),
    .alm_sec_i(as_), .alm_min_i(am), .alm_hour_i(ah), .match_o(match)
  );

  function automatic int dec(logic [7:0] b, bit is_hr);
    int v;
    logic [7:0] x = b;
    if (is_hr && !h24) x[7] = 1'b0;
    v = bin ? int'(x) : int'(x[7:4]) * 10 + int'(x[3:0]);
    if (is_hr && !h24) v = (v % 12) + (b[7] ? 12 : 0);
    return v;
  endfunction

  function automatic bit fld_ok(logic [7:0] a, logic [7:0] t, bit is_hr);
    return (a[7:6] == 2'b11) || (dec(a, is_hr) == dec(t, is_hr));
  endfunction

  function automatic bit exp_match(bit strobe);
    return strobe && !set_m && !hold && fld_ok(as_, ns, 0) && fld_ok(am, nm, 0) && fld_ok(ah, nh, 1);
  endfunction

  function automatic logic [7:0] enc(int v);
    return bin ? 8'(v) : {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] enc_hr(int h);
    int h12;
    if (h24) return enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12) | (h >= 12 ? 8'h80 : 8'h00);
  endfunction

  task automatic chk(bit act, bit exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: match_o=%0b expected=%0b", req, act, exp);
    end
  endtask

  // called at a negedge; strobes (optionally) and samples the registered result
  task automatic step(bit strobe, string req);
    bit e = exp_match(strobe);
    upd = strobe;
    @(posedge clk); @(negedge clk);
    upd = 1'b0;
    chk(match, e, req);
  endtask

  task automatic idle(string req);
    @(posedge clk); @(negedge clk);
    chk(match, 1'b0, req);
  endtask

  function automatic logic [7:0] pick_alm(logic [7:0] t, int v, bit is_hr);
    int r = $urandom_range(0, 9);
    if (r < 5) return t;
    if (r < 7) return 8'hC0 | 8'($urandom_range(0, 63));
    return is_hr ? enc_hr(v) : enc(v);
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(match, 1'b0, "R1");

    // R2: binary exact match, single-cycle pulse
    bin = 1; h24 = 1;
    ns = 8'd17; nm = 8'd42; nh = 8'd23; as_ = 8'd17; am = 8'd42; ah = 8'd23;
    step(1, "R2"); chk(match, 1'b1, "R2");
    idle("R2");

    // R3: BCD decode
    bin = 0;
    ns = 8'h59; nm = 8'h07; nh = 8'h21; as_ = 8'h59; am = 8'h07; ah = 8'h21;
    step(1, "R3");
    ns = 8'h3B; step(1, "R3");

    // R4: single wildcard field
    as_ = 8'hFF; step(1, "R4");
    as_ = 8'hC0; ns = 8'h00; step(1, "R4");

    // R5: all wildcard, different times
    as_ = 8'hC0; am = 8'hD5; ah = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      ns = enc(i * 19); nm = enc(i * 7); nh = enc(i * 5);
      step(1, "R5");
    end

    // R6: 12-hour equivalences
    h24 = 0; bin = 0; as_ = 8'h10; ns = 8'h10; am = 8'h30; nm = 8'h30;
    ah = 8'h12; nh = 8'h12; step(1, "R6");      // 12AM == 12AM
    ah = 8'h92; nh = 8'h92; step(1, "R6");      // 12PM == 12PM
    ah = 8'h12; nh = 8'h92; step(1, "R6");      // 12AM vs 12PM: no
    ah = 8'h81; nh = 8'h01; step(1, "R6");      // 1PM vs 1AM: no
    bin = 1; ah = 8'h8C; nh = 8'h8C; step(1, "R6");
    ah = 8'h0C; nh = 8'h00; step(1, "R6");      // binary 12AM vs 0

    // R7: no strobe with matching inputs
    h24 = 1; bin = 1; as_ = 8'd5; ns = 8'd5; am = 8'd6; nm = 8'd6; ah = 8'd7; nh = 8'd7;
    step(0, "R7");

    // R8: gating
    set_m = 1; step(1, "R8"); set_m = 0;
    hold = 1;  step(1, "R8"); hold = 0;
    step(1, "R8");

    // R9: one field off at a time
    am = 8'd8; step(1, "R9"); am = 8'd6;
    ah = 8'd9; step(1, "R9"); ah = 8'd7;

    // R10: alarm rewritten in the strobe cycle
    ns = 8'd30; as_ = 8'd29; step(1, "R10");
    as_ = 8'd30; step(1, "R10");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int s = $urandom_range(0, 59), m = $urandom_range(0, 59), h = $urandom_range(0, 23);
      bin = 1'($urandom_range(0, 1)); h24 = 1'($urandom_range(0, 1));
      set_m = ($urandom_range(0, 15) == 0); hold = ($urandom_range(0, 15) == 0);
      ns = enc(s); nm = enc(m); nh = enc_hr(h);
      as_ = pick_alm(ns, $urandom_range(0, 59), 0);
      am  = pick_alm(nm, $urandom_range(0, 59), 0);
      ah  = pick_alm(nh, $urandom_range(0, 23), 1);
      step($urandom_range(0, 7) != 0, "R9");
    end
    set_m = 0; hold = 0;
    idle("R7");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule